// File: doc/BRIEF.md
# Dual-class physical register free list

This block keeps track of which physical registers a register-renaming stage may hand out. There are two register classes, integer and floating point, and they share one index space. The integer registers sit at the bottom of that space. The floating-point registers follow directly above them. Each class keeps its free indices in a queue of its own.

A rename stage asks each class for a register through that class's allocate port. In the same cycle it gets back the oldest free index of that class. Registers come back to the block in one of two ways:
- through a generic release port, which sorts each index into the right queue by comparing it against the integer boundary;
- through per-class release ports, which push straight into that class's queue.

A per-register free bitmap catches two protocol errors. One is releasing a register that is already free. The other is handing out a register whose free bit is clear. Any refused operation leaves the state unchanged and raises an error pulse and a sticky error flag.

After reset, each queue holds the physical registers of its class that lie above that class's logical registers, in ascending order. Those registers are marked free. Every other register is marked in use, because the logical architectural state holds it.

Top module: `dual_free_list`

## Requirements
- R1: After reset, the integer queue holds indices NUM_LOG_INT to NUM_PHYS_INT-1 in ascending order. The floating-point queue holds NUM_PHYS_INT+NUM_LOG_FP to NUM_PHYS_INT+NUM_PHYS_FP-1 in ascending order. The free counts equal these sizes, and both error outputs are 0.
- R2: A granted allocation sets that class's alloc_vld to 1 in the cycle of the request. alloc_idx then shows the oldest queued index of the class. The entry is removed at the next rising edge, so indices leave in the order in which they entered.
- R3: A generic release with an index below NUM_PHYS_INT is queued in the integer queue. A generic release with an index from NUM_PHYS_INT up to the total count is queued in the floating-point queue.
- R4: A generic release with an index at or above the total register count changes no count and raises no error.
- R5: The per-class release ports queue any index in their own class without a range check. This includes an index of the other class and an index beyond the total. Such an index is later handed out unchanged.
- R6: An allocation request on an empty queue gets alloc_vld 0 and changes no count.
- R7: A release is refused if the register's free bit is already set. This covers any index that is queued or has never been allocated. A refused release changes no count.
- R8: Up to three releases can arrive in one cycle. They are taken in the order generic port, integer port, floating-point port. A later port that repeats an index accepted earlier in the same cycle is refused as a double release.
- R9: An allocation and a release on one class in the same cycle are both carried out. The index handed out is the head as it stood before the push. A release into an empty queue does not make a same-cycle allocation succeed.
- R10: A release that would push a queue beyond its class's physical register count is refused.
- R11: Every refused allocation or release raises err_evt for exactly the following cycle. It also sets err_sticky, which stays 1 until reset.
- R12: The two classes allocate independently, and both may be granted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_alloc_req | input | 1 | Request one integer register |
| int_alloc_vld | output | 1 | Integer request granted this cycle |
| int_alloc_idx | output | IDX_W | Granted integer index (head of the integer queue) |
| fp_alloc_req | input | 1 | Request one floating-point register |
| fp_alloc_vld | output | 1 | Floating-point request granted this cycle |
| fp_alloc_idx | output | IDX_W | Granted floating-point index |
| rel_vld | input | 1 | Generic release strobe |
| rel_idx | input | IDX_W | Generic release index, routed by value |
| int_rel_vld | input | 1 | Integer-queue release strobe |
| int_rel_idx | input | IDX_W | Index pushed to the integer queue |
| fp_rel_vld | input | 1 | Floating-point-queue release strobe |
| fp_rel_idx | input | IDX_W | Index pushed to the floating-point queue |
| int_nonempty | output | 1 | Integer queue holds at least one index |
| fp_nonempty | output | 1 | Floating-point queue holds at least one index |
| int_free_cnt | output | clog2(NUM_PHYS_INT+1) | Entries in the integer queue |
| fp_free_cnt | output | clog2(NUM_PHYS_FP+1) | Entries in the floating-point queue |
| err_evt | output | 1 | One-cycle pulse after a refused operation |
| err_sticky | output | 1 | Set by any refused operation until reset |

## Verification
Two functions meet in the same cycle:
- an allocation and a release on the same class, which tests whether the pop reads the head from before the push;
- two release ports carrying the same index, which tests whether the duplicate is caught before the bitmap update lands.

The bench provokes both on purpose, including the case where the queue is empty. It then runs a long stretch of random cycles with every port active at once. Each cycle is judged against a reference model of the queues and free bits, which checks the granted index, both counts and both error outputs.

// File: rtl/frl_pkg.sv
package frl_pkg;
  // Destination of a release arriving on the generic port.
  typedef enum logic [1:0] {
    RT_NONE = 2'd0,
    RT_INT  = 2'd1,
    RT_FP   = 2'd2
  } route_e;
endpackage

// File: rtl/frl_router.sv
module frl_router #(
  parameter int NUM_PHYS_INT = 64,
  parameter int TOTAL        = 128,
  parameter int IDX_W        = 7
) (
  input  logic             vld_i,
  input  logic [IDX_W-1:0] idx_i,
  output frl_pkg::route_e  route_o
);
  localparam logic [IDX_W:0] INT_LIMIT = (IDX_W+1)'(NUM_PHYS_INT);
  localparam logic [IDX_W:0] ALL_LIMIT = (IDX_W+1)'(TOTAL);

  logic [IDX_W:0] idx_ext;
  assign idx_ext = {1'b0, idx_i};

  always_comb begin
    route_o = frl_pkg::RT_NONE;
    if (vld_i) begin
      if (idx_ext < INT_LIMIT)      route_o = frl_pkg::RT_INT;
      else if (idx_ext < ALL_LIMIT) route_o = frl_pkg::RT_FP;
    end
  end
endmodule

// File: rtl/frl_queue.sv
module frl_queue #(
  parameter int DEPTH     = 64,
  parameter int IDX_W     = 7,
  parameter int FILL_BASE = 32,
  parameter int FILL_CNT  = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [1:0]                       push_i,
  input  logic [1:0][IDX_W-1:0]            push_idx_i,
  input  logic                             pop_i,
  output logic [IDX_W-1:0]                 head_o,
  output logic [$clog2(DEPTH+1)-1:0]       count_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [IDX_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d, wa, wb;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             we_a, we_b;
  logic [IDX_W-1:0] da, db;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  // Slot 0 is written first; a lone slot-1 push takes the first free entry.
  always_comb begin
    wa    = wr_q;
    wb    = ptr_inc(wr_q);
    we_a  = push_i[0] | push_i[1];
    da    = push_i[0] ? push_idx_i[0] : push_idx_i[1];
    we_b  = push_i[0] & push_i[1];
    db    = push_idx_i[1];
    wr_d  = we_b ? ptr_inc(wb) : (we_a ? wb : wr_q);
    rd_d  = pop_i ? ptr_inc(rd_q) : rd_q;
    cnt_d = cnt_q + CNT_W'(push_i[0]) + CNT_W'(push_i[1]) - CNT_W'(pop_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem_q[i] <= (i < FILL_CNT) ? IDX_W'(FILL_BASE + i) : '0;
      rd_q  <= '0;
      wr_q  <= PTR_W'(FILL_CNT % DEPTH);
      cnt_q <= CNT_W'(FILL_CNT);
    end else begin
      if (we_a) mem_q[wa] <= da;
      if (we_b) mem_q[wb] <= db;
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/frl_bitmap.sv
module frl_bitmap #(
  parameter int TOTAL  = 128,
  parameter int IDX_W  = 7,
  parameter int INT_LO = 32,
  parameter int INT_HI = 64,
  parameter int FP_LO  = 96,
  parameter int FP_HI  = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            set_i,
  input  logic [2:0][IDX_W-1:0] set_idx_i,
  input  logic [1:0]            clr_i,
  input  logic [1:0][IDX_W-1:0] clr_idx_i,
  output logic [TOTAL-1:0]      free_o
);
  logic [TOTAL-1:0] bits_q, bits_d;

  // Releases mark free; allocations mark busy. The two never share an index.
  always_comb begin
    bits_d = bits_q;
    for (int k = 0; k < 3; k++)
      if (set_i[k] && (int'(set_idx_i[k]) < TOTAL)) bits_d[set_idx_i[k]] = 1'b1;
    for (int k = 0; k < 2; k++)
      if (clr_i[k] && (int'(clr_idx_i[k]) < TOTAL)) bits_d[clr_idx_i[k]] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++)
        bits_q[i] <= ((i >= INT_LO) && (i < INT_HI)) || ((i >= FP_LO) && (i < FP_HI));
    end else begin
      bits_q <= bits_d;
    end
  end

  assign free_o = bits_q;
endmodule

// File: rtl/dual_free_list.sv
module dual_free_list #(
  parameter  int NUM_LOG_INT  = 32,
  parameter  int NUM_PHYS_INT = 64,
  parameter  int NUM_LOG_FP   = 32,
  parameter  int NUM_PHYS_FP  = 64,
  localparam int TOTAL        = NUM_PHYS_INT + NUM_PHYS_FP,
  localparam int IDX_W        = $clog2(TOTAL),
  localparam int ICNT_W       = $clog2(NUM_PHYS_INT+1),
  localparam int FCNT_W       = $clog2(NUM_PHYS_FP+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_alloc_req,
  output logic              int_alloc_vld,
  output logic [IDX_W-1:0]  int_alloc_idx,
  input  logic              fp_alloc_req,
  output logic              fp_alloc_vld,
  output logic [IDX_W-1:0]  fp_alloc_idx,
  input  logic              rel_vld,
  input  logic [IDX_W-1:0]  rel_idx,
  input  logic              int_rel_vld,
  input  logic [IDX_W-1:0]  int_rel_idx,
  input  logic              fp_rel_vld,
  input  logic [IDX_W-1:0]  fp_rel_idx,
  output logic              int_nonempty,
  output logic              fp_nonempty,
  output logic [ICNT_W-1:0] int_free_cnt,
  output logic [FCNT_W-1:0] fp_free_cnt,
  output logic              err_evt,
  output logic              err_sticky
);
  localparam int PAD = 1 << IDX_W;

  logic [IDX_W-1:0]  int_head, fp_head;
  logic [ICNT_W-1:0] int_cnt;
  logic [FCNT_W-1:0] fp_cnt;
  logic [TOTAL-1:0]  free_vec;
  logic [PAD-1:0]    free_pad;
  frl_pkg::route_e   gen_route;

  logic              int_ok, fp_ok, int_head_in, fp_head_in;
  logic              int_in, fp_in;
  logic [ICNT_W:0]   int_space;
  logic [FCNT_W:0]   fp_space;
  logic              gen_to_int, gen_to_fp, gen_acc, gen_err;
  logic              int_dup, int_acc, fp_dup, fp_acc;
  logic              err_any;
  logic              err_evt_q, err_evt_d, err_sticky_q, err_sticky_d;

  function automatic logic in_range(input logic [IDX_W-1:0] idx);
    return {1'b0, idx} < (IDX_W+1)'(TOTAL);
  endfunction

  // Out-of-range indices read back as "not free".
  always_comb begin
    free_pad = '0;
    free_pad[TOTAL-1:0] = free_vec;
  end

  frl_router #(.NUM_PHYS_INT(NUM_PHYS_INT), .TOTAL(TOTAL), .IDX_W(IDX_W)) router_i (
    .vld_i  (rel_vld),
    .idx_i  (rel_idx),
    .route_o(gen_route)
  );

  always_comb begin
    int_head_in  = in_range(int_head);
    fp_head_in   = in_range(fp_head);
    int_nonempty = (int_cnt != '0);
    fp_nonempty  = (fp_cnt != '0);
    // The double-allocate guard: a queued in-range index must be marked free.
    int_ok = int_alloc_req & int_nonempty & (~int_head_in | free_pad[int_head]);
    fp_ok  = fp_alloc_req & fp_nonempty & (~fp_head_in | free_pad[fp_head]);

    int_space = (ICNT_W+1)'(NUM_PHYS_INT) - {1'b0, int_cnt} + (ICNT_W+1)'(int_ok);
    fp_space  = (FCNT_W+1)'(NUM_PHYS_FP) - {1'b0, fp_cnt} + (FCNT_W+1)'(fp_ok);

    gen_to_int = (gen_route == frl_pkg::RT_INT) & ~free_pad[rel_idx] & (int_space != '0);
    gen_to_fp  = (gen_route == frl_pkg::RT_FP) & ~free_pad[rel_idx] & (fp_space != '0);
    gen_acc    = gen_to_int | gen_to_fp;
    gen_err    = (gen_route != frl_pkg::RT_NONE) & ~gen_acc;

    int_in  = in_range(int_rel_idx);
    int_dup = free_pad[int_rel_idx] | (gen_acc & (rel_idx == int_rel_idx));
    int_acc = int_rel_vld & ~int_dup & (int_space > (ICNT_W+1)'(gen_to_int));

    fp_in  = in_range(fp_rel_idx);
    fp_dup = free_pad[fp_rel_idx] | (gen_acc & (rel_idx == fp_rel_idx)) |
             (int_acc & int_in & (int_rel_idx == fp_rel_idx));
    fp_acc = fp_rel_vld & ~fp_dup & (fp_space > (FCNT_W+1)'(gen_to_fp));

    err_any = (int_alloc_req & ~int_ok) | (fp_alloc_req & ~fp_ok) | gen_err |
              (int_rel_vld & ~int_acc) | (fp_rel_vld & ~fp_acc);
    err_evt_d    = err_any;
    err_sticky_d = err_sticky_q | err_any;
  end

  frl_queue #(
    .DEPTH(NUM_PHYS_INT), .IDX_W(IDX_W),
    .FILL_BASE(NUM_LOG_INT), .FILL_CNT(NUM_PHYS_INT - NUM_LOG_INT)
  ) int_q_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    ({int_acc, gen_to_int}),
    .push_idx_i({int_rel_idx, rel_idx}),
    .pop_i     (int_ok),
    .head_o    (int_head),
    .count_o   (int_cnt)
  );

  frl_queue #(
    .DEPTH(NUM_PHYS_FP), .IDX_W(IDX_W),
    .FILL_BASE(NUM_PHYS_INT + NUM_LOG_FP), .FILL_CNT(NUM_PHYS_FP - NUM_LOG_FP)
  ) fp_q_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    ({fp_acc, gen_to_fp}),
    .push_idx_i({fp_rel_idx, rel_idx}),
    .pop_i     (fp_ok),
    .head_o    (fp_head),
    .count_o   (fp_cnt)
  );

  frl_bitmap #(
    .TOTAL(TOTAL), .IDX_W(IDX_W),
    .INT_LO(NUM_LOG_INT), .INT_HI(NUM_PHYS_INT),
    .FP_LO(NUM_PHYS_INT + NUM_LOG_FP), .FP_HI(TOTAL)
  ) bitmap_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    ({fp_acc & fp_in, int_acc & int_in, gen_acc}),
    .set_idx_i({fp_rel_idx, int_rel_idx, rel_idx}),
    .clr_i    ({fp_ok & fp_head_in, int_ok & int_head_in}),
    .clr_idx_i({fp_head, int_head}),
    .free_o   (free_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_evt_q    <= 1'b0;
      err_sticky_q <= 1'b0;
    end else begin
      err_evt_q    <= err_evt_d;
      err_sticky_q <= err_sticky_d;
    end
  end

  assign int_alloc_vld = int_ok;
  assign int_alloc_idx = int_head;
  assign fp_alloc_vld  = fp_ok;
  assign fp_alloc_idx  = fp_head;
  assign int_free_cnt  = int_cnt;
  assign fp_free_cnt   = fp_cnt;
  assign err_evt       = err_evt_q;
  assign err_sticky    = err_sticky_q;
endmodule

// File: rtl/frl_chk.sv
module frl_chk #(
  parameter int NUM_PHYS_INT = 64,
  parameter int NUM_PHYS_FP  = 64
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               int_alloc_req,
  input logic                               int_alloc_vld,
  input logic                               fp_alloc_req,
  input logic                               fp_alloc_vld,
  input logic                               rel_vld,
  input logic [$clog2(NUM_PHYS_INT+NUM_PHYS_FP)-1:0] rel_idx,
  input logic                               int_rel_vld,
  input logic                               fp_rel_vld,
  input logic                               int_nonempty,
  input logic                               fp_nonempty,
  input logic [$clog2(NUM_PHYS_INT+1)-1:0]  int_free_cnt,
  input logic [$clog2(NUM_PHYS_FP+1)-1:0]   fp_free_cnt,
  input logic                               err_evt,
  input logic                               err_sticky
);
  localparam int TOTAL  = NUM_PHYS_INT + NUM_PHYS_FP;
  localparam int IDX_W  = $clog2(TOTAL);
  localparam int ICNT_W = $clog2(NUM_PHYS_INT+1);
  localparam int FCNT_W = $clog2(NUM_PHYS_FP+1);

  // R6
  int_empty_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_alloc_req && !int_nonempty) |=> err_evt);
  // R6
  fp_empty_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_alloc_req && !fp_nonempty) |=> err_evt);
  // R2
  int_pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_alloc_vld && !rel_vld && !int_rel_vld) |=>
    (int_free_cnt == ICNT_W'($past(int_free_cnt) - 1'b1)));
  // R2
  fp_pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_alloc_vld && !rel_vld && !fp_rel_vld) |=>
    (fp_free_cnt == FCNT_W'($past(fp_free_cnt) - 1'b1)));
  // R4
  oob_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_vld && ({1'b0, rel_idx} >= (IDX_W+1)'(TOTAL)) && !int_rel_vld && !fp_rel_vld &&
     !int_alloc_req && !fp_alloc_req) |=>
    ($stable(int_free_cnt) && $stable(fp_free_cnt) && !err_evt));
  // R11
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);
  // R11
  evt_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |-> err_sticky);
  // R10
  int_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_free_cnt <= ICNT_W'(NUM_PHYS_INT));
  // R10
  fp_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp_free_cnt <= FCNT_W'(NUM_PHYS_FP));
endmodule

bind dual_free_list frl_chk #(.NUM_PHYS_INT(NUM_PHYS_INT), .NUM_PHYS_FP(NUM_PHYS_FP)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .int_alloc_req(int_alloc_req),
  .int_alloc_vld(int_alloc_vld),
  .fp_alloc_req (fp_alloc_req),
  .fp_alloc_vld (fp_alloc_vld),
  .rel_vld      (rel_vld),
  .rel_idx      (rel_idx),
  .int_rel_vld  (int_rel_vld),
  .fp_rel_vld   (fp_rel_vld),
  .int_nonempty (int_nonempty),
  .fp_nonempty  (fp_nonempty),
  .int_free_cnt (int_free_cnt),
  .fp_free_cnt  (fp_free_cnt),
  .err_evt      (err_evt),
  .err_sticky   (err_sticky)
);

// File: tb/dual_free_list_tb_top.sv
`timescale 1ns/1ps
module dual_free_list_tb_top;
  localparam int NLI = 4;
  localparam int NPI = 8;
  localparam int NLF = 4;
  localparam int NPF = 6;
  localparam int TOT = NPI + NPF;
  localparam int IW  = $clog2(TOT);
  localparam int ICW = $clog2(NPI+1);
  localparam int FCW = $clog2(NPF+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ia = 1'b0, fa = 1'b0, gv = 1'b0, iv = 1'b0, fv = 1'b0;
  logic [IW-1:0] gi = '0, ii = '0, fi = '0;
  logic ivld, fvld, ine, fne, evt, stk;
  logic [IW-1:0] iidx, fidx;
  logic [ICW-1:0] icnt;
  logic [FCW-1:0] fcnt;

  always #4 clk = ~clk;

  dual_free_list #(.NUM_LOG_INT(NLI), .NUM_PHYS_INT(NPI), .NUM_LOG_FP(NLF), .NUM_PHYS_FP(NPF)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .int_alloc_req(ia), .int_alloc_vld(ivld), .int_alloc_idx(iidx),
    .fp_alloc_req(fa), .fp_alloc_vld(fvld), .fp_alloc_idx(fidx),
    .rel_vld(gv), .rel_idx(gi), .int_rel_vld(iv), .int_rel_idx(ii),
    .fp_rel_vld(fv), .fp_rel_idx(fi),
    .int_nonempty(ine), .fp_nonempty(fne),
    .int_free_cnt(icnt), .fp_free_cnt(fcnt),
    .err_evt(evt), .err_sticky(stk)
  );

  typedef struct { bit v; int idx; string tag; } exp_t;
  exp_t sb_int[$], sb_fp[$];
  int   q_int[$], q_fp[$];
  bit   fr[TOT];
  int   pend_ic, pend_fc, cur_ic, cur_fc;
  bit   pend_ev, pend_st, cur_ev, cur_st;
  string cur_tag = "R1", prev_tag = "R1";
  bit   mon_en = 0, done = 0;
  int   checks = 0, errors = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    q_int.delete(); q_fp.delete(); sb_int.delete(); sb_fp.delete();
    for (int i = 0; i < TOT; i++) fr[i] = 0;
    for (int i = NLI; i < NPI; i++) begin q_int.push_back(i); fr[i] = 1; end
    for (int i = NPI + NLF; i < TOT; i++) begin q_fp.push_back(i); fr[i] = 1; end
    pend_ic = q_int.size(); pend_fc = q_fp.size(); pend_ev = 0; pend_st = 0;
    cur_ic = pend_ic; cur_fc = pend_fc; cur_ev = 0; cur_st = 0;
    cur_tag = "R1"; prev_tag = "R1";
  endtask

  task automatic do_reset();
    mon_en = 0;
    @(negedge clk);
    rst_n = 0; ia = 0; fa = 0; gv = 0; iv = 0; fv = 0;
    @(negedge clk);
    @(negedge clk);
    model_reset();
    rst_n = 1;
    mon_en = 1;
  endtask

  // Driver: applies one cycle of stimulus and advances the reference model.
  task automatic cyc(bit a_i, bit a_f, bit g_v, int g_i, bit i_v, int i_i, bit f_v, int f_i, string tag);
    bit oki, okf, err;
    int spi, spf, h;
    int add_i[$], add_f[$];
    @(negedge clk);
    cur_ic = pend_ic; cur_fc = pend_fc; cur_ev = pend_ev; cur_st = pend_st;
    prev_tag = cur_tag; cur_tag = tag;
    ia = a_i; fa = a_f; gv = g_v; gi = IW'(g_i); iv = i_v; ii = IW'(i_i); fv = f_v; fi = IW'(f_i);
    oki = a_i && q_int.size() > 0 && (q_int[0] >= TOT || fr[q_int[0]]);
    okf = a_f && q_fp.size() > 0 && (q_fp[0] >= TOT || fr[q_fp[0]]);
    if (a_i) sb_int.push_back('{oki, oki ? q_int[0] : 0, tag});
    if (a_f) sb_fp.push_back('{okf, okf ? q_fp[0] : 0, tag});
    err = (a_i && !oki) || (a_f && !okf);
    spi = NPI - q_int.size() + int'(oki);
    spf = NPF - q_fp.size() + int'(okf);
    if (g_v) begin
      if (g_i < NPI) begin
        if (fr[g_i] || spi < 1) err = 1;
        else begin add_i.push_back(g_i); fr[g_i] = 1; spi--; end
      end else if (g_i < TOT) begin
        if (fr[g_i] || spf < 1) err = 1;
        else begin add_f.push_back(g_i); fr[g_i] = 1; spf--; end
      end
    end
    if (i_v) begin
      if ((i_i < TOT && fr[i_i]) || spi < 1) err = 1;
      else begin add_i.push_back(i_i); if (i_i < TOT) fr[i_i] = 1; spi--; end
    end
    if (f_v) begin
      if ((f_i < TOT && fr[f_i]) || spf < 1) err = 1;
      else begin add_f.push_back(f_i); if (f_i < TOT) fr[f_i] = 1; spf--; end
    end
    if (oki) begin h = q_int.pop_front(); if (h < TOT) fr[h] = 0; end
    if (okf) begin h = q_fp.pop_front(); if (h < TOT) fr[h] = 0; end
    foreach (add_i[k]) q_int.push_back(add_i[k]);
    foreach (add_f[k]) q_fp.push_back(add_f[k]);
    pend_ic = q_int.size(); pend_fc = q_fp.size();
    pend_ev = err; pend_st = pend_st | err;
  endtask

  task automatic idle(string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // Monitor: compares grants with the scoreboard and state with the model.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (mon_en && !done) begin
        if (ia) begin
          e = sb_int.pop_front();
          chk(e.tag, "int_alloc_vld", int'(ivld), int'(e.v));
          if (e.v) chk(e.tag, "int_alloc_idx", int'(iidx), e.idx);
        end
        if (fa) begin
          e = sb_fp.pop_front();
          chk(e.tag, "fp_alloc_vld", int'(fvld), int'(e.v));
          if (e.v) chk(e.tag, "fp_alloc_idx", int'(fidx), e.idx);
        end
        chk(prev_tag, "int_free_cnt", int'(icnt), cur_ic);
        chk(prev_tag, "fp_free_cnt", int'(fcnt), cur_fc);
        chk(prev_tag, "int_nonempty", int'(ine), int'(cur_ic != 0));
        chk(prev_tag, "fp_nonempty", int'(fne), int'(cur_fc != 0));
        chk(prev_tag, "err_evt", int'(evt), int'(cur_ev));
        chk(prev_tag, "err_sticky", int'(stk), int'(cur_st));
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    idle("R1");
    // R1 ascending initial content, R2 FIFO hand-out
    for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0, 0, 0, 0, 0, "R1");
    cyc(0, 1, 0, 0, 0, 0, 0, 0, "R1");
    cyc(0, 1, 0, 0, 0, 0, 0, 0, "R2");
    // R6 empty allocation refused, R11 pulse then sticky
    cyc(1, 0, 0, 0, 0, 0, 0, 0, "R6");
    cyc(0, 1, 0, 0, 0, 0, 0, 0, "R6");
    idle("R11");
    idle("R11");

    do_reset();
    // R3 generic routing by boundary
    cyc(0, 0, 1, 0, 0, 0, 0, 0, "R3");
    cyc(0, 0, 1, 8, 0, 0, 0, 0, "R3");
    cyc(0, 0, 1, 3, 0, 0, 0, 0, "R3");
    for (int k = 0; k < 3; k++) cyc(0, 1, 0, 0, 0, 0, 0, 0, "R2");
    for (int k = 0; k < 6; k++) cyc(1, 0, 0, 0, 0, 0, 0, 0, "R2");
    // R4 out-of-range generic dropped
    cyc(0, 0, 1, 14, 0, 0, 0, 0, "R4");
    cyc(0, 0, 1, 15, 0, 0, 0, 0, "R4");
    idle("R4");

    do_reset();
    // R7 double release of queued registers
    cyc(0, 0, 1, 5, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, 1, 13, 0, 0, "R7");
    idle("R7");
    do_reset();
    // R8 same-cycle duplicates across ports
    cyc(0, 0, 1, 1, 1, 1, 1, 1, "R8");
    cyc(0, 0, 0, 0, 1, 9, 1, 9, "R8");
    idle("R8");
    do_reset();
    // R9 allocate and release together; empty queue plus release
    cyc(1, 0, 0, 0, 1, 2, 0, 0, "R9");
    for (int k = 0; k < 4; k++) cyc(0, 1, 0, 0, 0, 0, 0, 0, "R9");
    cyc(0, 1, 0, 0, 0, 0, 1, 10, "R9");
    cyc(0, 1, 0, 0, 0, 0, 0, 0, "R9");
    do_reset();
    // R5 class ports skip the range check
    cyc(0, 0, 0, 0, 1, 9, 1, 15, "R5");
    cyc(0, 0, 0, 0, 0, 0, 1, 2, "R5");
    for (int k = 0; k < 5; k++) cyc(1, 1, 0, 0, 0, 0, 0, 0, "R5");
    do_reset();
    // R10 full queue refuses a release; R12 both classes at once
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 1, k, 0, 0, "R10");
    cyc(0, 0, 0, 0, 1, 10, 0, 0, "R10");
    cyc(0, 0, 1, 9, 0, 0, 0, 0, "R10");
    cyc(1, 1, 0, 0, 0, 0, 0, 0, "R12");
    cyc(1, 1, 0, 0, 0, 0, 0, 0, "R12");
    idle("R12");

    // Mixed traffic on every port
    do_reset();
    for (int k = 0; k < 600; k++)
      cyc($urandom_range(0, 1), $urandom_range(0, 1),
          $urandom_range(0, 1), $urandom_range(0, 15),
          ($urandom_range(0, 3) == 0), $urandom_range(0, 15),
          ($urandom_range(0, 3) == 0), $urandom_range(0, 15), "R9");
    idle("R9");
    idle("R9");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule